// File: doc/BRIEF.md
# Countdown Timer With Interrupt

This block is a programmable countdown timer controlled through one 32-bit control word. A single write carries the start count, a countdown enable, an interrupt enable and an acknowledge request. While counting is enabled, each pulse on the `tick` input lowers the count by one. The count stops when it reaches zero.

The step from one to zero sets a sticky pending flag. The pending flag drives the interrupt line whenever the interrupt enable is set. The same flag appears as one bit of an 8-bit interrupt status word, which a wider status register elsewhere combines with the other interrupt sources. Software clears the flag by writing the control word with the acknowledge bit set. The tick source and the other status sources are outside this block.

Top module: `cdown_timer`

## Requirements
- R1: After a synchronous active-low reset, the count is zero, both enables are zero, the pending flag is clear, `irq` is low and `stat_word` is zero.
- R2: A write loads bits 19:0 of `wr_data` as the count, bit 24 as the countdown enable and bit 25 as the interrupt enable. From the next cycle on, `rd_data` returns the count in bits 19:0, the countdown enable in bit 24 and the interrupt enable in bit 25. All other bits of `rd_data` read zero; this includes bit 26, the acknowledge bit.
- R3: In a cycle with `tick` high, the countdown enable set, a nonzero count and no write, the count is one lower in the next cycle.
- R4: The count does not change in any cycle where `tick` is low or the countdown enable is clear.
- R5: A write in the same cycle as a tick loads the written value, and that tick has no effect.
- R6: When a tick moves the count from 1 to 0, the pending flag is set from the next cycle. It is reported as bit 5 (mask 0x20) of `stat_word`, and the other bits of `stat_word` stay zero.
- R7: At zero the count holds under further ticks, and no new pending event is raised. Loading a count of zero does not set the pending flag.
- R8: `irq` is high exactly when the pending flag and the interrupt enable are both set. The pending flag is set whether or not interrupts are enabled.
- R9: A write with bit 26 set clears the pending flag from the next cycle. A write with bit 26 clear leaves the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| tick | input | 1 | Countdown step pulse |
| rd_data | output | 32 | Control word readback |
| stat_word | output | 8 | Interrupt status slice; bit 5 is the timer pending flag |
| irq | output | 1 | Timer interrupt request |

## Verification
Every result of a write or a tick is due exactly one clock edge later. A write at an edge shows its new count, enables or cleared pending flag in `rd_data`, `stat_word` and `irq` straight after that edge. A tick on a count of 1 sets the pending flag in that same edge. The bench drives its inputs on the falling edge and lets one rising edge pass. It then compares all three outputs on the next falling edge against a model that it advances by one step per edge. Because of this, neither an early response nor a late one can match the model.

// File: rtl/cdown_timer_pkg.sv
// Package: shared field positions and the enable pair of the countdown timer.
// Assumes a 32-bit control word and an 8-bit status slice.
package cdown_timer_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 20;
    localparam int RUN_POS  = 24;
    localparam int IEN_POS  = 25;
    localparam int ACK_POS  = 26;
    localparam int STAT_W   = 8;
    localparam int STAT_POS = 5;

    typedef struct packed {
        logic run;   // countdown enable
        logic ien;   // interrupt enable
    } tmr_en_t;
endpackage

// File: rtl/cdown_count.sv
// Module: count register and enables. Loads on a write, and steps down by one
// on a qualified tick. It flags the tick that reaches zero.
// Assumes wr_en has priority over tick in the same cycle.
module cdown_count
    import cdown_timer_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_cnt,
    input  tmr_en_t       wr_en_bits,
    input  logic          tick,
    output logic [CW-1:0] cnt,
    output tmr_en_t       en_bits,
    output logic          hit_zero
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic step;

    // Decide whether this cycle steps the count.
    always_comb begin
        step     = tick && en_bits.run && (cnt != '0) && !wr_en;
        hit_zero = step && (cnt == ONE);
    end

    // Hold the count and enables; a write loads them, a qualified tick decrements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            en_bits <= '0;
        end else if (wr_en) begin
            cnt     <= wr_cnt;
            en_bits <= wr_en_bits;
        end else if (step) begin
            cnt     <= cnt - ONE;
        end
    end
endmodule

// File: rtl/cdown_pend.sv
// Module: sticky pending flag. It is set by the zero-reaching tick and cleared
// by an acknowledge write.
// Assumes set and acknowledge never coincide, because a write suppresses the tick.
module cdown_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic pend
);
    // Track the pending state of the timer event.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= 1'b0;
        else if (set_i)  pend <= 1'b1;
        else if (ack_i)  pend <= 1'b0;
    end
endmodule

// File: rtl/cdown_view.sv
// Module: output mapping. It assembles the readback word, the status slice and
// the interrupt line from the registered state.
// Assumes purely combinational use; the acknowledge bit reads as zero.
module cdown_view
    import cdown_timer_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int WW = WORD_W,
    parameter int SW = STAT_W,
    parameter int SP = STAT_POS
) (
    input  logic [CW-1:0] cnt,
    input  tmr_en_t       en_bits,
    input  logic          pend,
    output logic [WW-1:0] rd_data,
    output logic [SW-1:0] stat_word,
    output logic          irq
);
    // Build the readback word from its fields.
    always_comb begin
        rd_data          = '0;
        rd_data[CW-1:0]  = cnt;
        rd_data[RUN_POS] = en_bits.run;
        rd_data[IEN_POS] = en_bits.ien;
    end

    // Place the pending flag in its status slot and gate the interrupt.
    always_comb begin
        stat_word     = '0;
        stat_word[SP] = pend;
        irq           = pend && en_bits.ien;
    end
endmodule

// File: rtl/cdown_timer.sv
// Module: top of the countdown timer. It splits a control write into fields and
// ties together the count, pending and view blocks.
// Assumes tick is a one-cycle pulse that is synchronous to clk.
module cdown_timer
    import cdown_timer_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int WW = WORD_W,
    parameter int SW = STAT_W,
    parameter int SP = STAT_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [WW-1:0] wr_data,
    input  logic          tick,
    output logic [WW-1:0] rd_data,
    output logic [SW-1:0] stat_word,
    output logic          irq
);
    tmr_en_t       wr_en_bits;
    tmr_en_t       en_bits;
    logic [CW-1:0] cnt;
    logic          hit_zero;
    logic          ack_req;
    logic          pend;

    // Split the write data into enable fields and the acknowledge request.
    always_comb begin
        wr_en_bits.run = wr_data[RUN_POS];
        wr_en_bits.ien = wr_data[IEN_POS];
        ack_req        = wr_en && wr_data[ACK_POS];
    end

    cdown_count #(.CW(CW)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_cnt     (wr_data[CW-1:0]),
        .wr_en_bits (wr_en_bits),
        .tick       (tick),
        .cnt        (cnt),
        .en_bits    (en_bits),
        .hit_zero   (hit_zero)
    );

    cdown_pend u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (hit_zero),
        .ack_i (ack_req),
        .pend  (pend)
    );

    cdown_view #(.CW(CW), .WW(WW), .SW(SW), .SP(SP)) u_view (
        .cnt       (cnt),
        .en_bits   (en_bits),
        .pend      (pend),
        .rd_data   (rd_data),
        .stat_word (stat_word),
        .irq       (irq)
    );
endmodule

// File: rtl/cdown_timer_chk.sv
// Checker: properties of the countdown timer at its ports, bound to the top.
module cdown_timer_chk
    import cdown_timer_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int WW = WORD_W,
    parameter int SW = STAT_W,
    parameter int SP = STAT_POS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [WW-1:0] wr_data,
    input logic          tick,
    input logic [WW-1:0] rd_data,
    input logic [SW-1:0] stat_word,
    input logic          irq
);
    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CW-1:0] == $past(wr_data[CW-1:0]));

    // R3
    decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_data[RUN_POS] && rd_data[CW-1:0] != '0 && !wr_en)
        |=> rd_data[CW-1:0] == $past(rd_data[CW-1:0]) - CW'(1));

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (!tick || !rd_data[RUN_POS])) |=> $stable(rd_data[CW-1:0]));

    // R6
    pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[SP]) |-> ($past(rd_data[CW-1:0]) == CW'(1) && $past(tick)));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[CW-1:0] == '0 && !wr_en) |=> rd_data[CW-1:0] == '0);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (stat_word[SP] && rd_data[IEN_POS]));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[ACK_POS]) |=> !stat_word[SP]);
endmodule

bind cdown_timer cdown_timer_chk #(.CW(CW), .WW(WW), .SW(SW), .SP(SP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tick      (tick),
    .rd_data   (rd_data),
    .stat_word (stat_word),
    .irq       (irq)
);

// File: tb/test_cdown_timer.sv
module test_cdown_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tick = 1'b0;
    logic [31:0] rd_data;
    logic [7:0]  stat_word;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [19:0] m_cnt = '0;
    logic        m_run = 1'b0;
    logic        m_ien = 1'b0;
    logic        m_pend = 1'b0;

    cdown_timer i_cdown_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick(tick), .rd_data(rd_data), .stat_word(stat_word), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_rd();
        logic [31:0] v = '0;
        v[19:0] = m_cnt;
        v[24]   = m_run;
        v[25]   = m_ien;
        return v;
    endfunction

    function automatic logic [7:0] exp_stat();
        return {2'b00, m_pend, 5'b00000};
    endfunction

    task automatic check(input string tag);
        checks++;
        if (rd_data !== exp_rd()) begin
            errors++;
            $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, exp_rd());
        end
        if (stat_word !== exp_stat()) begin
            errors++;
            $display("FAIL %s stat_word actual %h expected %h", tag, stat_word, exp_stat());
        end
        if (irq !== (m_pend && m_ien)) begin
            errors++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, m_pend && m_ien);
        end
    endtask

    // One cycle: drive on the falling edge, pass one rising edge, advance the model, check.
    task automatic step(input logic w, input logic [31:0] d, input logic t, input string tag);
        wr_en = w; wr_data = d; tick = t;
        @(posedge clk);
        if (w) begin
            m_cnt = d[19:0]; m_run = d[24]; m_ien = d[25];
            if (d[26]) m_pend = 1'b0;
        end else if (t && m_run && m_cnt != 0) begin
            if (m_cnt == 20'd1) m_pend = 1'b1;
            m_cnt = m_cnt - 20'd1;
        end
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        // R2: load with both enables, ack bit and spare bits set
        step(1, 32'hFFF0_0005 & ~32'h0100_0000 | 32'h0300_0005, 0, "R2 load");
        step(1, 32'h0300_0003, 0, "R2 load2");
        // R3 decrement
        step(0, '0, 1, "R3 decrement");
        // R4 no tick, then disabled
        step(0, '0, 0, "R4 no tick");
        step(1, 32'h0200_0004, 0, "R4 disabled load");
        step(0, '0, 1, "R4 tick while disabled");
        // R5 write beats tick
        step(1, 32'h0100_0002, 1, "R5 write with tick");
        // R6 reach zero, interrupts off
        step(0, '0, 1, "R3 to one");
        step(0, '0, 1, "R6 reach zero");
        // R7 hold at zero
        step(0, '0, 1, "R7 hold zero");
        // R9 plain write keeps pending; R8 irq appears once enabled
        step(1, 32'h0200_0000, 0, "R9 write without ack");
        step(1, 32'h0200_0000 | 32'h0400_0000, 0, "R9 ack clears");
        // R7 load zero does not set pending
        step(1, 32'h0300_0000, 1, "R7 load zero");
        step(0, '0, 1, "R7 tick at zero");
        // R8 with irq enabled from start
        step(1, 32'h0300_0001, 0, "R8 arm");
        step(0, '0, 1, "R8 fires");
        // boundary: maximum count
        step(1, 32'h010F_FFFF, 0, "R2 max count");
        step(0, '0, 1, "R3 from max");
        // random phase: R3 R4 R5 R6 R7 R8 R9 against the model
        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            int r = $urandom_range(0, 9);
            d = $urandom;
            d[19:0] = 20'($urandom_range(0, 4));
            if (r == 0) step(1, d, $urandom_range(0, 1) == 1, "R5/R9 random write");
            else step(0, d, $urandom_range(0, 3) != 0, "R3/R6/R7 random tick");
        end
        // R1 reset mid-run
        step(1, 32'h0300_0001, 0, "R1 pre");
        step(0, '0, 1, "R1 pend");
        rst_n = 1'b0;
        @(negedge clk);
        m_cnt = '0; m_run = 0; m_ien = 0; m_pend = 0;
        check("R1 reset again");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule